// File: doc/BRIEF.md
# Debug Access Security Filter

This block stands between the bus master of an external debug port and the system bus. It checks every debugger transaction against the device-protection flag. An unprotected device lets every debugger access through unchanged. A protected device lets through only the accesses that land in the debugger's own alias of the debug-unit register space. Every other access is dropped at the filter. The filter then answers that access itself with an error and all-zero read data, and it sets a sticky error flag that the debugger clears explicitly.

The debug unit's register file is decoded at two places in the address map. The low window is the CPU's view and the window directly above it is the debugger's view. Both windows select the same register offset, and a flag carries which window was used. A forwarded debugger access that arrives through the external window while the device is protected is also marked as restricted, so the register file can refuse the commands that are not allowed in that state.

The CPU has a separate decode port for the debug-unit registers. That port never looks at the protection flag. All outputs are registered and appear one clock after the input that causes them. Only one debugger transaction may be outstanding at a time.

Top module: `dbg_access_filter`

## Requirements
- R1: With `prot_i` low, a debugger request appears on the system side in the following cycle, with the same address, direction and write data and with no error response.
- R2: With `prot_i` high, a debugger request whose offset from the debug-unit base is at least 0x100 and below 0x2000 is forwarded as in R1.
- R3: With `prot_i` high, any other debugger request is not forwarded (`sys_req_valid` stays low). In the following cycle `dbg_rsp_valid` and `dbg_rsp_err` are both high.
- R4: The response to a discarded request carries `dbg_rsp_rdata` equal to zero, whether the request was a read or a write.
- R5: `dbg_sticky_err` is high in the same cycle as any response with `dbg_rsp_err` high, whether the filter produced the error or the system returned it.
- R6: `dbg_sticky_err` stays high until a cycle in which `dbg_sticky_clr` is high and no new error occurs. When a clear and a new error arrive together, the flag stays set.
- R7: A system response (`sys_rsp_valid`) reaches the debugger one cycle later, with its data and error bit unchanged.
- R8: Offsets 0x000–0x0FF (internal window) and 0x100–0x1FF (external window) decode to the same 8-bit register offset (offset bits 7:0). The external flag equals offset bit 8. Outside 0x000–0x1FF the hit flag is low.
- R9: `sys_req_restricted` is high only for a forwarded request made while `prot_i` was high that hit the external window.
- R10: A CPU request that hits either window raises `cpu_du_valid` in the next cycle with the decoded window flag and offset, whatever the value of `prot_i`.
- R11: While `rst` is high and in the first cycle after it, all valid outputs, the error outputs and `dbg_sticky_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_i | input | 1 | Device-protection flag, from the non-volatile security bit |
| dbg_req_valid | input | 1 | Debugger request strobe |
| dbg_req_write | input | 1 | Debugger request is a write |
| dbg_req_addr | input | AW | Debugger byte address |
| dbg_req_wdata | input | DW | Debugger write data |
| dbg_sticky_clr | input | 1 | Write-one-to-clear of the sticky error flag |
| dbg_rsp_valid | output | 1 | Response to the debugger |
| dbg_rsp_err | output | 1 | Response is an error |
| dbg_rsp_rdata | output | DW | Response read data |
| dbg_sticky_err | output | 1 | Sticky error flag |
| sys_req_valid | output | 1 | Forwarded request strobe |
| sys_req_write | output | 1 | Forwarded request is a write |
| sys_req_addr | output | AW | Forwarded address |
| sys_req_wdata | output | DW | Forwarded write data |
| sys_req_du_hit | output | 1 | Forwarded request hits a debug-unit window |
| sys_req_du_ext | output | 1 | Forwarded request used the external window |
| sys_req_du_off | output | WL | Register offset inside the window |
| sys_req_restricted | output | 1 | Command restrictions apply |
| sys_rsp_valid | input | 1 | System response strobe |
| sys_rsp_err | input | 1 | System response error |
| sys_rsp_rdata | input | DW | System response data |
| cpu_req_valid | input | 1 | CPU request strobe |
| cpu_req_addr | input | AW | CPU byte address |
| cpu_du_valid | output | 1 | CPU request hits a debug-unit window |
| cpu_du_ext | output | 1 | CPU used the external window |
| cpu_du_off | output | WL | CPU register offset |

## Verification
A wrong pass/discard decision becomes visible one cycle after the request. The wrong value shows on `sys_req_valid` and on the error response at the same time, so the bench checks both at that cycle for addresses exactly on each edge of the allowed range. A sticky flag in the wrong state shows on `dbg_sticky_err` in the response cycle. The cycle after a clear pulse exposes it as well. A broken window decoder returns a wrong offset or external flag with the forwarded request, or on the CPU port one cycle after the CPU request.

// File: rtl/dbg_filter_pkg.sv
package dbg_filter_pkg;
  localparam int unsigned ADDR_W_DEF   = 32;
  localparam int unsigned DATA_W_DEF   = 32;
  localparam int unsigned WIN_LOG2_DEF = 8;
  localparam logic [31:0] DU_BASE_DEF  = 32'h4100_2000;
  localparam int unsigned ALLOW_LO_DEF = 32'h0000_0100;
  localparam int unsigned ALLOW_HI_DEF = 32'h0000_2000;

  typedef struct packed {
    logic hit;
    logic ext;
  } win_tag_t;
endpackage

// File: rtl/dbg_win_decode.sv
module dbg_win_decode #(
  parameter int unsigned AW = 32,
  parameter int unsigned WL = 8,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic [AW-1:0]           addr,
  output dbg_filter_pkg::win_tag_t tag,
  output logic [WL-1:0]           off
);
  logic [AW-1:0] rel;
  logic          above;

  always_comb begin
    above   = (addr >= BASE);
    rel     = addr - BASE;
    tag.hit = above && (rel[AW-1:WL+1] == '0);
    tag.ext = rel[WL];
    off     = rel[WL-1:0];
  end
endmodule

// File: rtl/dbg_range_screen.sv
module dbg_range_screen #(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter int unsigned LO = 32'h100,
  parameter int unsigned HI = 32'h2000
) (
  input  logic [AW-1:0] addr,
  input  logic          prot,
  output logic          pass
);
  localparam logic [AW-1:0] LO_A = AW'(LO);
  localparam logic [AW-1:0] HI_A = AW'(HI);

  logic [AW-1:0] rel;
  logic          in_alias;

  always_comb begin
    rel      = addr - BASE;
    in_alias = (addr >= BASE) && (rel >= LO_A) && (rel < HI_A);
    pass     = !prot || in_alias;
  end
endmodule

// File: rtl/dbg_sticky_flag.sv
module dbg_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q && !clr_i) |=> q);

  // R6
  sticky_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
endmodule

// File: rtl/dbg_access_filter.sv
module dbg_access_filter #(
  parameter int unsigned AW = dbg_filter_pkg::ADDR_W_DEF,
  parameter int unsigned DW = dbg_filter_pkg::DATA_W_DEF,
  parameter int unsigned WL = dbg_filter_pkg::WIN_LOG2_DEF,
  parameter logic [AW-1:0] DU_BASE = AW'(dbg_filter_pkg::DU_BASE_DEF),
  parameter int unsigned ALLOW_LO = dbg_filter_pkg::ALLOW_LO_DEF,
  parameter int unsigned ALLOW_HI = dbg_filter_pkg::ALLOW_HI_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prot_i,
  input  logic          dbg_req_valid,
  input  logic          dbg_req_write,
  input  logic [AW-1:0] dbg_req_addr,
  input  logic [DW-1:0] dbg_req_wdata,
  input  logic          dbg_sticky_clr,
  output logic          dbg_rsp_valid,
  output logic          dbg_rsp_err,
  output logic [DW-1:0] dbg_rsp_rdata,
  output logic          dbg_sticky_err,
  output logic          sys_req_valid,
  output logic          sys_req_write,
  output logic [AW-1:0] sys_req_addr,
  output logic [DW-1:0] sys_req_wdata,
  output logic          sys_req_du_hit,
  output logic          sys_req_du_ext,
  output logic [WL-1:0] sys_req_du_off,
  output logic          sys_req_restricted,
  input  logic          sys_rsp_valid,
  input  logic          sys_rsp_err,
  input  logic [DW-1:0] sys_rsp_rdata,
  input  logic          cpu_req_valid,
  input  logic [AW-1:0] cpu_req_addr,
  output logic          cpu_du_valid,
  output logic          cpu_du_ext,
  output logic [WL-1:0] cpu_du_off
);
  import dbg_filter_pkg::*;

  logic     pass;
  logic     fwd, drop;
  logic     err_evt;
  win_tag_t dbg_tag, cpu_tag;
  logic [WL-1:0] dbg_off, cpu_off;

  dbg_range_screen #(.AW(AW), .BASE(DU_BASE), .LO(ALLOW_LO), .HI(ALLOW_HI)) u_screen (
    .addr (dbg_req_addr),
    .prot (prot_i),
    .pass (pass)
  );

  dbg_win_decode #(.AW(AW), .WL(WL), .BASE(DU_BASE)) u_dbg_dec (
    .addr (dbg_req_addr),
    .tag  (dbg_tag),
    .off  (dbg_off)
  );

  dbg_win_decode #(.AW(AW), .WL(WL), .BASE(DU_BASE)) u_cpu_dec (
    .addr (cpu_req_addr),
    .tag  (cpu_tag),
    .off  (cpu_off)
  );

  always_comb begin
    fwd     = dbg_req_valid && pass;
    drop    = dbg_req_valid && !pass;
    err_evt = drop || (sys_rsp_valid && sys_rsp_err);
  end

  // forward path
  always_ff @(posedge clk) begin
    if (rst) begin
      sys_req_valid      <= 1'b0;
      sys_req_write      <= 1'b0;
      sys_req_addr       <= '0;
      sys_req_wdata      <= '0;
      sys_req_du_hit     <= 1'b0;
      sys_req_du_ext     <= 1'b0;
      sys_req_du_off     <= '0;
      sys_req_restricted <= 1'b0;
    end else begin
      sys_req_valid <= fwd;
      if (fwd) begin
        sys_req_write      <= dbg_req_write;
        sys_req_addr       <= dbg_req_addr;
        sys_req_wdata      <= dbg_req_wdata;
        sys_req_du_hit     <= dbg_tag.hit;
        sys_req_du_ext     <= dbg_tag.hit && dbg_tag.ext;
        sys_req_du_off     <= dbg_tag.hit ? dbg_off : '0;
        sys_req_restricted <= prot_i && dbg_tag.hit && dbg_tag.ext;
      end
    end
  end

  // response path
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rsp_valid <= 1'b0;
      dbg_rsp_err   <= 1'b0;
      dbg_rsp_rdata <= '0;
    end else begin
      dbg_rsp_valid <= drop || sys_rsp_valid;
      dbg_rsp_err   <= err_evt;
      dbg_rsp_rdata <= (sys_rsp_valid && !drop) ? sys_rsp_rdata : '0;
    end
  end

  dbg_sticky_flag u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (err_evt),
    .clr_i (dbg_sticky_clr),
    .q     (dbg_sticky_err)
  );

  // CPU decode port, no protection screening
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_du_valid <= 1'b0;
      cpu_du_ext   <= 1'b0;
      cpu_du_off   <= '0;
    end else begin
      cpu_du_valid <= cpu_req_valid && cpu_tag.hit;
      if (cpu_req_valid && cpu_tag.hit) begin
        cpu_du_ext <= cpu_tag.ext;
        cpu_du_off <= cpu_off;
      end
    end
  end

  // R1
  open_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_req_valid && !prot_i) |=> (sys_req_valid && sys_req_addr == $past(dbg_req_addr)));

  // R3
  blocked_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> (!sys_req_valid && dbg_rsp_valid && dbg_rsp_err));

  // R4
  blocked_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> (dbg_rsp_rdata == '0));

  // R5
  err_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rsp_valid && dbg_rsp_err) |-> dbg_sticky_err);

  // R9
  restricted_only_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_req_valid && !prot_i) |=> !sys_req_restricted);

  // R10
  cpu_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_tag.hit) |=> cpu_du_valid);
endmodule

// File: tb/tb_dbg_access_filter.sv
module tb_dbg_access_filter;
  localparam logic [31:0] BASE = 32'h4100_2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_i = 1'b0;
  logic dbg_req_valid = 1'b0, dbg_req_write = 1'b0;
  logic [31:0] dbg_req_addr = '0, dbg_req_wdata = '0;
  logic dbg_sticky_clr = 1'b0;
  logic dbg_rsp_valid, dbg_rsp_err, dbg_sticky_err;
  logic [31:0] dbg_rsp_rdata;
  logic sys_req_valid, sys_req_write, sys_req_du_hit, sys_req_du_ext, sys_req_restricted;
  logic [31:0] sys_req_addr, sys_req_wdata;
  logic [7:0] sys_req_du_off;
  logic sys_rsp_valid = 1'b0, sys_rsp_err = 1'b0;
  logic [31:0] sys_rsp_rdata = '0;
  logic cpu_req_valid = 1'b0;
  logic [31:0] cpu_req_addr = '0;
  logic cpu_du_valid, cpu_du_ext;
  logic [7:0] cpu_du_off;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbg_access_filter dut (
    .clk(clk), .rst(rst), .prot_i(prot_i),
    .dbg_req_valid(dbg_req_valid), .dbg_req_write(dbg_req_write),
    .dbg_req_addr(dbg_req_addr), .dbg_req_wdata(dbg_req_wdata),
    .dbg_sticky_clr(dbg_sticky_clr),
    .dbg_rsp_valid(dbg_rsp_valid), .dbg_rsp_err(dbg_rsp_err),
    .dbg_rsp_rdata(dbg_rsp_rdata), .dbg_sticky_err(dbg_sticky_err),
    .sys_req_valid(sys_req_valid), .sys_req_write(sys_req_write),
    .sys_req_addr(sys_req_addr), .sys_req_wdata(sys_req_wdata),
    .sys_req_du_hit(sys_req_du_hit), .sys_req_du_ext(sys_req_du_ext),
    .sys_req_du_off(sys_req_du_off), .sys_req_restricted(sys_req_restricted),
    .sys_rsp_valid(sys_rsp_valid), .sys_rsp_err(sys_rsp_err),
    .sys_rsp_rdata(sys_rsp_rdata),
    .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr),
    .cpu_du_valid(cpu_du_valid), .cpu_du_ext(cpu_du_ext), .cpu_du_off(cpu_du_off)
  );

  typedef struct packed {
    logic        prot;
    logic        wr;
    logic [31:0] addr;
    logic        fwd;
    logic        hit;
    logic        ext;
    logic [7:0]  off;
    logic        restr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, BASE + 32'h004,  1'b1, 1'b1, 1'b0, 8'h04, 1'b0},
    '{1'b0, 1'b1, 32'h2000_0000,   1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b0, BASE + 32'h104,  1'b1, 1'b1, 1'b1, 8'h04, 1'b1},
    '{1'b1, 1'b1, BASE + 32'h1FF,  1'b1, 1'b1, 1'b1, 8'hFF, 1'b1},
    '{1'b1, 1'b0, BASE + 32'h100,  1'b1, 1'b1, 1'b1, 8'h00, 1'b1},
    '{1'b1, 1'b0, BASE + 32'h0FF,  1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b1, BASE + 32'h1FFF, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b0, BASE + 32'h2000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b1, 32'h0000_0000,   1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b0, BASE + 32'h004,  1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b0, 1'b0, BASE + 32'h2000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
    '{1'b1, 1'b0, BASE - 32'h4,    1'b0, 1'b0, 1'b0, 8'h00, 1'b0}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue one debugger request; returns after the result cycle
  task automatic dbg_issue(input logic p, input logic w, input logic [31:0] a, input logic clr);
    @(negedge clk);
    prot_i = p; dbg_req_valid = 1'b1; dbg_req_write = w;
    dbg_req_addr = a; dbg_req_wdata = a ^ 32'h5A5A_0000; dbg_sticky_clr = clr;
    @(negedge clk);
    dbg_req_valid = 1'b0; dbg_sticky_clr = 1'b0;
  endtask

  task automatic sys_answer(input logic e, input logic [31:0] d);
    sys_rsp_valid = 1'b1; sys_rsp_err = e; sys_rsp_rdata = d;
    @(negedge clk);
    sys_rsp_valid = 1'b0; sys_rsp_err = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "sys_req_valid", 32'(sys_req_valid), 0);
    check("R11", "dbg_rsp_valid", 32'(dbg_rsp_valid), 0);
    check("R11", "sticky", 32'(dbg_sticky_err), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "cpu_du_valid", 32'(cpu_du_valid), 0);
    check("R11", "dbg_rsp_err", 32'(dbg_rsp_err), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = !v.prot ? "R1" : (v.fwd ? "R2" : "R3");
      dbg_issue(v.prot, v.wr, v.addr, 1'b0);
      check(tg, "sys_req_valid", 32'(sys_req_valid), 32'(v.fwd));
      if (v.fwd) begin
        check(tg, "addr", sys_req_addr, v.addr);
        check(tg, "write", 32'(sys_req_write), 32'(v.wr));
        check(tg, "wdata", sys_req_wdata, v.addr ^ 32'h5A5A_0000);
        check(tg, "no rsp", 32'(dbg_rsp_valid), 0);
        check("R8", "hit", 32'(sys_req_du_hit), 32'(v.hit));
        check("R8", "ext", 32'(sys_req_du_ext), 32'(v.ext));
        check("R8", "off", 32'(sys_req_du_off), 32'(v.off));
        check("R9", "restricted", 32'(sys_req_restricted), 32'(v.restr));
        sys_answer(1'b0, ~v.addr);
        check("R7", "rsp_valid", 32'(dbg_rsp_valid), 1);
        check("R7", "rsp_err", 32'(dbg_rsp_err), 0);
        check("R7", "rsp_rdata", dbg_rsp_rdata, ~v.addr);
        check("R5", "sticky clean", 32'(dbg_sticky_err), 0);
      end else begin
        check("R3", "rsp_valid", 32'(dbg_rsp_valid), 1);
        check("R3", "rsp_err", 32'(dbg_rsp_err), 1);
        check("R4", "rsp_rdata", dbg_rsp_rdata, 0);
        check("R5", "sticky set", 32'(dbg_sticky_err), 1);
        dbg_sticky_clr = 1'b1;
        @(negedge clk);
        dbg_sticky_clr = 1'b0;
        check("R6", "sticky cleared", 32'(dbg_sticky_err), 0);
      end
    end

    // R5 / R7: error returned by the system
    dbg_issue(1'b0, 1'b0, BASE + 32'h008, 1'b0);
    sys_answer(1'b1, 32'h0000_1234);
    check("R7", "sys err passed", 32'(dbg_rsp_err), 1);
    check("R7", "sys err data", dbg_rsp_rdata, 32'h0000_1234);
    check("R5", "sticky on sys err", 32'(dbg_sticky_err), 1);
    // R6: later good response does not clear
    dbg_issue(1'b0, 1'b0, BASE + 32'h00C, 1'b0);
    sys_answer(1'b0, 32'h1);
    check("R6", "sticky held", 32'(dbg_sticky_err), 1);
    // R6: clear together with a new discard keeps it set
    dbg_issue(1'b1, 1'b0, 32'h0000_0010, 1'b1);
    check("R6", "set beats clear", 32'(dbg_sticky_err), 1);
    @(negedge clk);
    dbg_sticky_clr = 1'b1;
    @(negedge clk);
    dbg_sticky_clr = 1'b0;
    check("R6", "clear alone", 32'(dbg_sticky_err), 0);

    // R10 / R8: CPU port ignores protection
    prot_i = 1'b1;
    cpu_req_valid = 1'b1; cpu_req_addr = BASE + 32'h004;
    @(negedge clk);
    check("R10", "cpu valid int", 32'(cpu_du_valid), 1);
    check("R10", "cpu ext int", 32'(cpu_du_ext), 0);
    check("R10", "cpu off int", 32'(cpu_du_off), 32'h04);
    check("R10", "no fwd from cpu", 32'(sys_req_valid), 0);
    cpu_req_addr = BASE + 32'h1A0;
    @(negedge clk);
    check("R8", "cpu ext mirror", 32'(cpu_du_ext), 1);
    check("R8", "cpu off mirror", 32'(cpu_du_off), 32'hA0);
    cpu_req_addr = BASE + 32'h300;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check("R8", "cpu miss", 32'(cpu_du_valid), 0);

    // R11: reset clears a set flag
    dbg_issue(1'b1, 1'b1, 32'h0000_0020, 1'b0);
    check("R5", "sticky before reset", 32'(dbg_sticky_err), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "sticky after reset", 32'(dbg_sticky_err), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule